// File: doc/BRIEF.md
# SMRAM Access Window Decoder

This block sits in the memory request path of a host bridge. It checks each memory request against three system-management memory windows and decides what happens to it: it goes to DRAM, it is redirected to the legacy video path, or it is aborted. The three windows are a fixed 128 KB compatible window at 0xA0000, a 128 KB high segment just below 0xFEE00000, and a top-of-memory segment. The top-of-memory segment ends at the base of graphics stolen memory, and its size is chosen from a small encoded set.

Software sets up the windows through plain configuration inputs. These are per-window enables, one shared open bit, a lock request and the segment size code. A request qualified by `reqValid` produces one response a cycle later. The response carries one hit flag per window, exactly one routing decision, and the DRAM address to use. For a granted high-segment access, that address is folded onto the compatible range. Only the processor can reach system-management memory. A hit from any other bus master is aborted.

Top module: `smram_window_decoder`

## Requirements
- R1: When `compEn` is 1, addresses 0x000A0000 to 0x000BFFFF hit the compatible window (`hitComp`). When `compEn` is 0, no address hits it.
- R2: When `highEn` is 1, addresses 0xFEDE0000 to 0xFEDFFFFF hit the high segment (`hitHigh`). A granted high-segment access reports `dramAddr` = 0x000A0000 + (address − 0xFEDE0000).
- R3: When `tsegEn` is 1, the top segment (`hitTseg`) covers `stolenBase` − size up to `stolenBase` − 1. `tsegSizeSel` gives the size: 00 = 1 MB, 01 = 2 MB, 10 = 8 MB. Code 11 turns the segment off.
- R4: A request whose `reqSrc` is not 00 and that hits any window is aborted. This holds for 01 (DMI), 10 (PCI Express) and 11 (reserved), and it holds whatever the state of `smmActive` or the open bit.
- R5: A processor request (`reqSrc` 00) that hits a window goes to DRAM when `smmActive` is 1, or when `smramOpen` is 1 and the lock is not in force.
- R6: A processor request that hits a window but is not granted access never goes to DRAM. A compatible-window hit is redirected to legacy video. A high-segment or top-segment hit is aborted.
- R7: A pulse on `smramLockSet` engages a lock that stays set until reset. The lock already applies to a request in the same cycle as the pulse. While the lock is set, `smramOpen` has no effect.
- R8: A request that hits no window goes to DRAM with `dramAddr` equal to the request address, from any source.
- R9: `respValid` and the results rise exactly one cycle after `reqValid`. Each response has exactly one of `toDram`, `redirect`, `abort` set. Every output is 0 in cycles without a response.
- R10: While `rstN` is low, every output is 0 and the lock is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request qualifier |
| reqAddr | input | ADDR_W | Request address |
| reqSrc | input | 2 | Issuing master: 00 processor, 01 DMI, 10 PCI Express, 11 reserved |
| smmActive | input | 1 | Processor is in system management mode |
| compEn | input | 1 | Compatible window enable |
| highEn | input | 1 | High segment enable |
| tsegEn | input | 1 | Top segment enable |
| smramOpen | input | 1 | Make enabled windows visible outside SMM |
| smramLockSet | input | 1 | Engage the sticky lock |
| tsegSizeSel | input | 2 | Top segment size code |
| stolenBase | input | ADDR_W | Base of graphics stolen memory (top segment end) |
| respValid | output | 1 | Response valid |
| hitComp | output | 1 | Compatible window hit |
| hitHigh | output | 1 | High segment hit |
| hitTseg | output | 1 | Top segment hit |
| toDram | output | 1 | Route to DRAM |
| redirect | output | 1 | Route to legacy video |
| abort | output | 1 | Request aborted |
| dramAddr | output | ADDR_W | DRAM address when `toDram` is set, else 0 |

## Verification
The only internal state is the sticky lock, plus one stage of response registers. A lock that drops too early shows at the ports on the first open-but-locked processor hit: it goes to DRAM when it should be redirected or aborted. A lock that survives reset shows as the same kind of wrong routing, in the first open-bit request after reset. A broken response stage shows in the very next cycle in one of three ways: a response arrives at the wrong time, more than one route flag is set, or an output stays high between requests. The scoreboard finds each of these on the response where it happens.

// File: rtl/smram_pkg.sv
package smram_pkg;

  typedef enum logic [1:0] {
    SRC_CPU  = 2'b00,
    SRC_DMI  = 2'b01,
    SRC_PCIE = 2'b10,
    SRC_RSVD = 2'b11
  } reqSrc_e;

  typedef enum logic [1:0] {
    TSZ_1M  = 2'b00,
    TSZ_2M  = 2'b01,
    TSZ_8M  = 2'b10,
    TSZ_OFF = 2'b11
  } tsegSize_e;

  typedef struct packed {
    logic comp;
    logic high;
    logic tseg;
  } winHit_t;

  // Strobes from the routing control to the datapath register stage.
  typedef struct packed {
    logic load;
    logic toDram;
    logic redirect;
    logic abort;
    logic useAlias;
  } routeStrobe_t;

endpackage

// File: rtl/smram_window_path.sv
module smram_window_path
  import smram_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned WIN_LOG2  = 17,
  parameter logic [ADDR_W-1:0] COMP_BASE = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFEDE_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              compEn,
  input  logic              highEn,
  input  logic              tsegEn,
  input  logic [1:0]        tsegSizeSel,
  input  logic [ADDR_W-1:0] stolenBase,
  input  routeStrobe_t      strobe,
  output winHit_t           hitNow,
  output logic              respValid,
  output winHit_t           hitReg,
  output logic              toDram,
  output logic              redirect,
  output logic              abort,
  output logic [ADDR_W-1:0] dramAddr
);

  localparam int unsigned TAG_W = ADDR_W - WIN_LOG2;

  logic [TAG_W-1:0]  reqTag;
  logic [ADDR_W-1:0] tsegBytes;
  logic [ADDR_W-1:0] distToTop;
  logic              tsegLive;
  logic [ADDR_W-1:0] aliasAddr;

  assign reqTag = reqAddr[ADDR_W-1:WIN_LOG2];

  // Segment size from its code; code 11 yields zero and disables the window.
  always_comb begin
    tsegBytes = '0;
    unique case (tsegSize_e'(tsegSizeSel))
      TSZ_1M:  tsegBytes[20] = 1'b1;
      TSZ_2M:  tsegBytes[21] = 1'b1;
      TSZ_8M:  tsegBytes[23] = 1'b1;
      default: tsegBytes = '0;
    endcase
  end

  assign tsegLive  = tsegEn && (tsegSizeSel != TSZ_OFF);
  // Distance below the stolen base; no underflow because it is only used when addr < base.
  assign distToTop = stolenBase - reqAddr;

  always_comb begin
    hitNow.comp = compEn && (reqTag == COMP_BASE[ADDR_W-1:WIN_LOG2]);
    hitNow.high = highEn && (reqTag == HIGH_BASE[ADDR_W-1:WIN_LOG2]);
    hitNow.tseg = tsegLive && (reqAddr < stolenBase) && (distToTop <= tsegBytes);
  end

  assign aliasAddr = {COMP_BASE[ADDR_W-1:WIN_LOG2], reqAddr[WIN_LOG2-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      hitReg    <= '0;
      toDram    <= 1'b0;
      redirect  <= 1'b0;
      abort     <= 1'b0;
      dramAddr  <= '0;
    end else begin
      respValid <= strobe.load;
      hitReg    <= strobe.load ? hitNow : '0;
      toDram    <= strobe.load && strobe.toDram;
      redirect  <= strobe.load && strobe.redirect;
      abort     <= strobe.load && strobe.abort;
      if (strobe.load && strobe.toDram)
        dramAddr <= strobe.useAlias ? aliasAddr : reqAddr;
      else
        dramAddr <= '0;
    end
  end

endmodule

// File: rtl/smram_route_ctrl.sv
module smram_route_ctrl
  import smram_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic [1:0]   reqSrc,
  input  logic         smmActive,
  input  logic         smramOpen,
  input  logic         smramLockSet,
  input  winHit_t      hitNow,
  output routeStrobe_t strobe
);

  logic lockReg;
  logic lockEff;
  logic anyHit;
  logic fromCpu;
  logic granted;

  // Sticky lock: set by a pulse, cleared only by reset.
  always_ff @(posedge clk) begin
    if (!rstN) lockReg <= 1'b0;
    else       lockReg <= lockReg | smramLockSet;
  end

  assign lockEff = lockReg | smramLockSet;
  assign anyHit  = hitNow.comp | hitNow.high | hitNow.tseg;
  assign fromCpu = (reqSrc_e'(reqSrc) == SRC_CPU);
  assign granted = smmActive | (smramOpen & ~lockEff);

  always_comb begin
    strobe          = '0;
    strobe.load     = reqValid;
    if (!anyHit) begin
      strobe.toDram = 1'b1;
    end else if (!fromCpu) begin
      strobe.abort  = 1'b1;
    end else if (granted) begin
      strobe.toDram   = 1'b1;
      strobe.useAlias = hitNow.high;
    end else if (hitNow.comp) begin
      strobe.redirect = 1'b1;
    end else begin
      strobe.abort  = 1'b1;
    end
  end

endmodule

// File: rtl/smram_window_decoder.sv
module smram_window_decoder
  import smram_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSrc,
  input  logic              smmActive,
  input  logic              compEn,
  input  logic              highEn,
  input  logic              tsegEn,
  input  logic              smramOpen,
  input  logic              smramLockSet,
  input  logic [1:0]        tsegSizeSel,
  input  logic [ADDR_W-1:0] stolenBase,
  output logic              respValid,
  output logic              hitComp,
  output logic              hitHigh,
  output logic              hitTseg,
  output logic              toDram,
  output logic              redirect,
  output logic              abort,
  output logic [ADDR_W-1:0] dramAddr
);

  winHit_t      hitNow;
  winHit_t      hitReg;
  routeStrobe_t strobe;

  smram_route_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqSrc       (reqSrc),
    .smmActive    (smmActive),
    .smramOpen    (smramOpen),
    .smramLockSet (smramLockSet),
    .hitNow       (hitNow),
    .strobe       (strobe)
  );

  smram_window_path #(.ADDR_W(ADDR_W)) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .reqAddr     (reqAddr),
    .compEn      (compEn),
    .highEn      (highEn),
    .tsegEn      (tsegEn),
    .tsegSizeSel (tsegSizeSel),
    .stolenBase  (stolenBase),
    .strobe      (strobe),
    .hitNow      (hitNow),
    .respValid   (respValid),
    .hitReg      (hitReg),
    .toDram      (toDram),
    .redirect    (redirect),
    .abort       (abort),
    .dramAddr    (dramAddr)
  );

  assign hitComp = hitReg.comp;
  assign hitHigh = hitReg.high;
  assign hitTseg = hitReg.tseg;

endmodule

// File: rtl/smram_window_checks.sv
module smram_window_checks #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [1:0]        reqSrc,
  input logic              smmActive,
  input logic              smramLockSet,
  input logic              respValid,
  input logic              hitComp,
  input logic              hitHigh,
  input logic              hitTseg,
  input logic              toDram,
  input logic              redirect,
  input logic              abort,
  input logic [ADDR_W-1:0] dramAddr
);

  logic anyHitOut;
  assign anyHitOut = hitComp | hitHigh | hitTseg;

  p_resp_timing_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (respValid == $past(reqValid)));

  p_one_route_r9: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> ($countones({toDram, redirect, abort}) == 1));

  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> ({toDram, redirect, abort, anyHitOut} == 4'b0 && dramAddr == '0));

  p_io_abort_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && respValid && anyHitOut && ($past(reqSrc) != 2'b00)) |-> abort);

  p_smm_grant_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && respValid && ($past(reqSrc) == 2'b00) && $past(smmActive)) |-> toDram);

  p_lock_hides_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && respValid && anyHitOut && ($past(reqSrc) == 2'b00)
     && !$past(smmActive) && $past(smramLockSet)) |-> !toDram);

  p_alias_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && hitHigh && toDram) |-> (dramAddr[ADDR_W-1:17] == ADDR_W'(32'h000A_0000) >> 17));

endmodule

bind smram_window_decoder smram_window_checks #(.ADDR_W(ADDR_W)) u_checks (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqSrc       (reqSrc),
  .smmActive    (smmActive),
  .smramLockSet (smramLockSet),
  .respValid    (respValid),
  .hitComp      (hitComp),
  .hitHigh      (hitHigh),
  .hitTseg      (hitTseg),
  .toDram       (toDram),
  .redirect     (redirect),
  .abort        (abort),
  .dramAddr     (dramAddr)
);

// File: tb/test_smram_window_decoder.sv
module test_smram_window_decoder;

  localparam int AW = 32;
  localparam logic [31:0] HB = 32'hFEDE_0000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [1:0]    reqSrc = '0;
  logic          smmActive = 1'b0;
  logic          compEn = 1'b0, highEn = 1'b0, tsegEn = 1'b0;
  logic          smramOpen = 1'b0, smramLockSet = 1'b0;
  logic [1:0]    tsegSizeSel = '0;
  logic [AW-1:0] stolenBase = '0;
  logic          respValid, hitComp, hitHigh, hitTseg, toDram, redirect, abort;
  logic [AW-1:0] dramAddr;

  // Shadow configuration, applied to the inputs only inside the driver.
  logic          nComp = 1, nHigh = 1, nTseg = 1, nOpen = 0, nLock = 0;
  logic [1:0]    nSize = 2'b00;
  logic [AW-1:0] nStolen = 32'h3F80_0000;
  logic          lockModel = 0;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  typedef struct {
    logic [5:0]    flags;  // hitComp hitHigh hitTseg toDram redirect abort
    logic [AW-1:0] addr;
    string         tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  smram_window_decoder #(.ADDR_W(AW)) i_smram_window_decoder (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqSrc(reqSrc),
    .smmActive(smmActive), .compEn(compEn), .highEn(highEn), .tsegEn(tsegEn),
    .smramOpen(smramOpen), .smramLockSet(smramLockSet), .tsegSizeSel(tsegSizeSel),
    .stolenBase(stolenBase), .respValid(respValid), .hitComp(hitComp), .hitHigh(hitHigh),
    .hitTseg(hitTseg), .toDram(toDram), .redirect(redirect), .abort(abort), .dramAddr(dramAddr)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t predict(input logic [AW-1:0] a, input logic [1:0] src,
                                   input logic smm, input logic lk, input string tag);
    exp_t e;
    logic c, h, t, any;
    logic [AW-1:0] bytes;
    c = nComp && a >= 32'h000A_0000 && a <= 32'h000B_FFFF;
    h = nHigh && a >= HB && a <= HB + 32'h1_FFFF;
    case (nSize)
      2'b00: bytes = 32'h0010_0000;
      2'b01: bytes = 32'h0020_0000;
      2'b10: bytes = 32'h0080_0000;
      default: bytes = 0;
    endcase
    t = nTseg && nSize != 2'b11 && a < nStolen && a >= nStolen - bytes;
    any = c | h | t;
    e.tag = tag;
    e.addr = 0;
    if (!any) begin
      e.flags = {3'b000, 3'b100}; e.addr = a;
    end else if (src != 2'b00) begin
      e.flags = {c, h, t, 3'b001};
    end else if (smm || (nOpen && !lk)) begin
      e.flags = {c, h, t, 3'b100};
      e.addr = h ? (32'h000A_0000 + (a - HB)) : a;
    end else if (c) begin
      e.flags = {c, h, t, 3'b010};
    end else begin
      e.flags = {c, h, t, 3'b001};
    end
    return e;
  endfunction

  task automatic send(input logic [AW-1:0] a, input logic [1:0] src, input logic smm, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqSrc = src; smmActive = smm;
    compEn = nComp; highEn = nHigh; tsegEn = nTseg; smramOpen = nOpen;
    smramLockSet = nLock; tsegSizeSel = nSize; stolenBase = nStolen;
    lockModel = lockModel | nLock;
    q.push_back(predict(a, src, smm, lockModel, tag));
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    reqValid = 1'b0; smramLockSet = 1'b0; nLock = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic quiet(input string tag);
    chk({respValid, hitComp, hitHigh, hitTseg, toDram, redirect, abort} == 7'b0 && dramAddr == 0,
        tag, {respValid, hitComp, hitHigh, hitTseg, toDram, redirect, abort}, 0);
  endtask

  // Monitor: compare each response with the oldest expectation.
  always @(negedge clk) begin
    if (rstN && respValid) begin
      if (q.size() == 0) begin
        chk(0, "R9 response without request", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({hitComp, hitHigh, hitTseg, toDram, redirect, abort} == e.flags, e.tag,
            {hitComp, hitHigh, hitTseg, toDram, redirect, abort}, e.flags);
        if (e.flags[2])
          chk(dramAddr == e.addr, {e.tag, " dramAddr"}, dramAddr, e.addr);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    quiet("R10 reset state");
    @(negedge clk); rstN = 1'b1;
    idle(2);
    quiet("R9 idle after reset");

    // Misses from any source
    send(32'h0010_0000, 2'b00, 0, "R8 cpu miss");
    send(32'h1234_5678, 2'b01, 0, "R8 dmi miss");
    // Compatible window, closed, outside SMM
    send(32'h000A_1234, 2'b00, 0, "R6 R1 comp redirect");
    send(32'h000B_FFFF, 2'b00, 0, "R1 comp top edge");
    send(32'h000C_0000, 2'b00, 0, "R1 just above comp");
    send(32'h0009_FFFF, 2'b00, 0, "R1 just below comp");
    idle(3);
    quiet("R9 quiet between bursts");
    // SMM grants
    send(32'h000A_1234, 2'b00, 1, "R5 comp in smm");
    send(HB + 32'h1234, 2'b00, 1, "R2 high alias in smm");
    send(32'hFEDF_FFFF, 2'b00, 1, "R2 high top edge");
    send(32'hFEE0_0000, 2'b00, 1, "R2 above high");
    send(32'hFEDD_FFFF, 2'b00, 0, "R2 below high");
    send(HB + 32'h10, 2'b00, 0, "R6 high closed abort");
    // Top segment, 1 MB
    send(32'h3F7F_FFFF, 2'b00, 0, "R3 tseg top byte closed");
    send(32'h3F70_0000, 2'b00, 1, "R3 tseg bottom 1M smm");
    send(32'h3F6F_FFFF, 2'b00, 0, "R3 below tseg 1M");
    send(32'h3F80_0000, 2'b00, 0, "R3 at stolen base");
    nSize = 2'b01;
    send(32'h3F60_0000, 2'b00, 1, "R3 tseg bottom 2M");
    send(32'h3F5F_FFFF, 2'b00, 1, "R3 below tseg 2M");
    nSize = 2'b10;
    send(32'h3F00_0000, 2'b00, 0, "R3 tseg bottom 8M");
    send(32'h3EFF_FFFF, 2'b00, 0, "R3 below tseg 8M");
    nSize = 2'b11;
    send(32'h3F7F_FFFF, 2'b00, 0, "R3 tseg code 11 off");
    nSize = 2'b00;
    // Other masters
    send(32'h3F7F_0000, 2'b01, 1, "R4 dmi tseg abort");
    send(32'h000A_0000, 2'b10, 1, "R4 pcie comp abort");
    send(HB, 2'b11, 0, "R4 rsvd high abort");
    idle(3);
    // Open bit, then lock
    nOpen = 1;
    send(32'h000A_4000, 2'b00, 0, "R5 open comp");
    send(32'h3F7F_0000, 2'b00, 0, "R5 open tseg");
    send(32'h000A_4000, 2'b01, 0, "R4 open dmi abort");
    nLock = 1;
    send(32'h000A_4000, 2'b00, 0, "R7 lock same cycle");
    nLock = 0;
    send(32'h000A_4000, 2'b00, 0, "R7 lock sticky comp");
    send(32'h3F7F_0000, 2'b00, 0, "R7 lock sticky tseg");
    send(32'h3F7F_0000, 2'b00, 1, "R7 locked smm grant");
    idle(3);
    nComp = 0;
    send(32'h000A_4000, 2'b00, 0, "R1 comp disabled");
    nComp = 1;
    idle(3);
    // Reset clears the lock
    @(negedge clk); rstN = 1'b0; lockModel = 0;
    repeat (2) @(negedge clk);
    quiet("R10 reset mid-run");
    rstN = 1'b1;
    send(32'h000A_4000, 2'b00, 0, "R7 lock cleared by reset");
    idle(4);
    chk(q.size() == 0, "R9 all responses seen", q.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule